// File: doc/BRIEF.md
# Gated Conversion Clock Selector

This block sits on the converter side of a successive-approximation ADC and supplies the conversion clock. It selects either an internal clock or an external clock pin as the source. The internal clock is an enable derived from the system clock. The external pin is synchronized, and each of its rising edges becomes a one-cycle enable. Every conversion lets exactly sixteen enables reach the sequencer. The sequencer is modelled here as a step counter. Once the sixteenth step is taken, an end-of-conversion flag blocks any further source edges, however many arrive.

A conversion begins on a falling edge of the active-low start input. The busy flag is low from that point until one cycle after the end-of-conversion flag is raised, and that extra cycle models loading the result into the output shift register. While the read enable is low, each sequencer enable is copied to a monitor clock output one cycle later. The same two power inputs also decode into two low-power modes. In either mode, start edges are ignored.

Top module: `convClkGate`

## Requirements
- R1: The source is internal (`clkSrcExt` = 0) out of reset, and again once no falling edge of the synchronized external pin has been seen for 64 system clocks. Any synchronized falling edge selects the external source (`clkSrcExt` = 1) from the next cycle.
- R2: Each conversion delivers exactly 16 `seqTick` pulses. `endConv` rises in the cycle after the 16th, and `seqTick` stays low while `endConv` is high, even if the source keeps toggling.
- R3: `monClk` is high in the cycle after a `seqTick` only if `rdN` was low in that `seqTick` cycle. Otherwise it is low, including after the 16th step until the next conversion.
- R4: A high-to-low change of `startN` between two clock edges, seen while `busy` is high and `shdnN` is high, drives `busy` low in the next cycle. A start edge that arrives while `busy` is low, including the result-load cycle, is ignored.
- R5: `busy` stays low for the whole conversion and returns high two cycles after `endConv` rises. It is never high while `endConv` is low.
- R6: With `shdnN` low, `rdN` high gives `sleepMode` = 1 and `rdN` low gives `napMode` = 1. With `shdnN` high, both are 0.
- R7: While `shdnN` is low, start edges are ignored and `busy` stays high.
- R8: The external pin passes through two flops before edge detection. A rising change on the pin produces a `seqTick` in the cycle after the second clock edge that follows it. The internal source produces one enable every 4 system clocks.
- R9: `stepCount` is cleared when a conversion starts and counts the `seqTick` pulses of the conversion modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extClkIn | input | 1 | External conversion clock pin, asynchronous |
| startN | input | 1 | Active-low start; a falling edge starts a conversion |
| rdN | input | 1 | Active-low read enable |
| shdnN | input | 1 | Active-low shutdown |
| seqTick | output | 1 | Conversion clock enable to the sequencer |
| stepCount | output | 4 | Sequencer step counter |
| endConv | output | 1 | End-of-conversion flag, gates the conversion clock |
| busy | output | 1 | Low while a conversion is in progress |
| monClk | output | 1 | Monitor copy of the conversion enables |
| clkSrcExt | output | 1 | 1 when the external source is selected |
| sleepMode | output | 1 | Sleep power-down mode active |
| napMode | output | 1 | Nap power-down mode active |

## Verification
Two functions can fall in the same cycle here. A new start edge can land in the cycle where the end-of-conversion gate closes, and the source pin can keep producing edges just as the sixteenth step is taken. The bench toggles the external pin well past sixteen edges in every external conversion. It also places a start edge exactly on the first cycle in which `endConv` is high. A cycle-by-cycle behavioural model then judges both cases: the late edges must produce no `seqTick`, and the start must leave `busy` high once the result-load cycle has passed.

// File: rtl/convClkPkg.sv
package convClkPkg;
  typedef enum logic [1:0] {
    CV_IDLE = 2'd0,
    CV_RUN  = 2'd1,
    CV_LOAD = 2'd2
  } convState_t;

  typedef struct packed {
    logic startConv;
    logic runEn;
  } ctlStrobe_t;
endpackage

// File: rtl/convClkPath.sv
module convClkPath
  import convClkPkg::*;
#(
  parameter int STEPS       = 16,
  parameter int INT_DIV     = 4,
  parameter int HOLD_CYCLES = 64,
  parameter int SYNC_STAGES = 2,
  localparam int STEP_W     = $clog2(STEPS),
  localparam int HOLD_W     = $clog2(HOLD_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extClkIn,
  input  logic              rdN,
  input  ctlStrobe_t        ctl,
  output logic              seqTick,
  output logic [STEP_W-1:0] stepCount,
  output logic              endConv,
  output logic              monClk,
  output logic              clkSrcExt
);
  localparam int DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extPrev;
  logic [HOLD_W-1:0]      holdCnt;
  logic                   intTick;
  logic                   extRise;
  logic                   extFall;
  logic                   useInt;
  logic                   convEdge;

  // pin synchronizer and edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      extPrev <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extClkIn};
      extPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign extRise = syncQ[SYNC_STAGES-1] & ~extPrev;
  assign extFall = ~syncQ[SYNC_STAGES-1] & extPrev;

  // held-high detector: saturating count since last falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      holdCnt <= HOLD_W'(HOLD_CYCLES);
    else if (extFall)
      holdCnt <= '0;
    else if (holdCnt != HOLD_W'(HOLD_CYCLES))
      holdCnt <= holdCnt + 1'b1;
  end

  assign useInt    = (holdCnt == HOLD_W'(HOLD_CYCLES));
  assign clkSrcExt = ~useInt;

  // internal clock enable
  generate
    if (INT_DIV > 1) begin : g_intDiv
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          divCnt <= '0;
        else if (divCnt == DIV_W'(INT_DIV - 1))
          divCnt <= '0;
        else
          divCnt <= divCnt + 1'b1;
      end
      assign intTick = (divCnt == DIV_W'(INT_DIV - 1));
    end else begin : g_intFull
      assign intTick = 1'b1;
    end
  endgenerate

  assign convEdge = useInt ? intTick : extRise;
  assign seqTick  = ctl.runEn & ~endConv & convEdge;

  // sequencer step counter and end-of-conversion gate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCount <= '0;
      endConv   <= 1'b1;
    end else if (ctl.startConv) begin
      stepCount <= '0;
      endConv   <= 1'b0;
    end else if (seqTick) begin
      if (stepCount == STEP_W'(STEPS - 1)) begin
        stepCount <= '0;
        endConv   <= 1'b1;
      end else begin
        stepCount <= stepCount + 1'b1;
      end
    end
  end

  // monitor copy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      monClk <= 1'b0;
    else
      monClk <= seqTick & ~rdN;
  end

  // R1
  src_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    extFall |=> clkSrcExt);

  // R2
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    endConv |-> !seqTick);

  // R2
  last_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqTick && stepCount == STEP_W'(STEPS - 1)) |=> endConv);

  // R3
  mon_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    monClk |-> ($past(seqTick) && !$past(rdN)));
endmodule

// File: rtl/convClkCtl.sv
module convClkCtl
  import convClkPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startN,
  input  logic       shdnN,
  input  logic       rdN,
  input  logic       doneIn,
  output ctlStrobe_t ctl,
  output logic       busy,
  output logic       sleepMode,
  output logic       napMode
);
  convState_t stateQ;
  logic       startPrev;
  logic       startFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      startPrev <= 1'b1;
    else
      startPrev <= startN;
  end

  assign startFall     = startPrev & ~startN;
  assign ctl.startConv = (stateQ == CV_IDLE) & startFall & shdnN;
  assign ctl.runEn     = (stateQ == CV_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      stateQ <= CV_IDLE;
    else begin
      unique case (stateQ)
        CV_IDLE: if (ctl.startConv) stateQ <= CV_RUN;
        CV_RUN:  if (doneIn) stateQ <= CV_LOAD;
        CV_LOAD: stateQ <= CV_IDLE;
        default: stateQ <= CV_IDLE;
      endcase
    end
  end

  assign busy      = (stateQ == CV_IDLE);
  assign sleepMode = ~shdnN & rdN;
  assign napMode   = ~shdnN & ~rdN;

  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startFall) |=> !busy || $past(doneIn));

  // R5
  busy_after_eoc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> doneIn);

  // R7
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!shdnN && busy) |=> busy);

  // R6
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shdnN |-> (sleepMode != napMode));
endmodule

// File: rtl/convClkGate.sv
module convClkGate
  import convClkPkg::*;
#(
  parameter int STEPS       = 16,
  parameter int INT_DIV     = 4,
  parameter int HOLD_CYCLES = 64,
  localparam int STEP_W     = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extClkIn,
  input  logic              startN,
  input  logic              rdN,
  input  logic              shdnN,
  output logic              seqTick,
  output logic [STEP_W-1:0] stepCount,
  output logic              endConv,
  output logic              busy,
  output logic              monClk,
  output logic              clkSrcExt,
  output logic              sleepMode,
  output logic              napMode
);
  ctlStrobe_t ctlS;

  convClkCtl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .startN    (startN),
    .shdnN     (shdnN),
    .rdN       (rdN),
    .doneIn    (endConv),
    .ctl       (ctlS),
    .busy      (busy),
    .sleepMode (sleepMode),
    .napMode   (napMode)
  );

  convClkPath #(
    .STEPS       (STEPS),
    .INT_DIV     (INT_DIV),
    .HOLD_CYCLES (HOLD_CYCLES),
    .SYNC_STAGES (2)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .extClkIn  (extClkIn),
    .rdN       (rdN),
    .ctl       (ctlS),
    .seqTick   (seqTick),
    .stepCount (stepCount),
    .endConv   (endConv),
    .monClk    (monClk),
    .clkSrcExt (clkSrcExt)
  );
endmodule

// File: tb/tb_convClkGate.sv
module tb_convClkGate;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extClkIn = 1'b1;
  logic       startN = 1'b1;
  logic       rdN = 1'b1;
  logic       shdnN = 1'b1;
  logic       seqTick, endConv, busy, monClk, clkSrcExt, sleepMode, napMode;
  logic [3:0] stepCount;

  int checks = 0;
  int failures = 0;
  int tickCnt = 0;
  int monCnt = 0;
  bit extToggle = 0;
  int extHalf = 3;
  bit finished = 0;

  // reference model state
  int hist[$] = '{1, 1, 1};
  int since = 64;
  int divc = 0;
  int mst = 0;
  int steps = 0;
  int done = 1;
  int startPrev = 1;
  int mon = 0;

  convClkGate dut (
    .clk(clk), .rstN(rstN), .extClkIn(extClkIn), .startN(startN),
    .rdN(rdN), .shdnN(shdnN), .seqTick(seqTick), .stepCount(stepCount),
    .endConv(endConv), .busy(busy), .monClk(monClk), .clkSrcExt(clkSrcExt),
    .sleepMode(sleepMode), .napMode(napMode)
  );

  always #4 clk = ~clk;

  function automatic int expTick();
    int cEdge;
    cEdge = (since >= 64) ? (divc == 3) : (hist[1] == 1 && hist[2] == 0);
    return (mst == 1 && done == 0 && cEdge != 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      hist = '{1, 1, 1}; since = 64; divc = 0; mst = 0; steps = 0;
      done = 1; startPrev = 1; mon = 0;
    end else begin
      int tk;
      int fl;
      tk = expTick();
      fl = (hist[1] == 0 && hist[2] == 1) ? 1 : 0;
      mon = (tk != 0 && !rdN) ? 1 : 0;
      if (mst == 0) begin
        if (startPrev == 1 && !startN && shdnN) begin
          mst = 1; steps = 0; done = 0;
        end
      end else if (mst == 1) begin
        if (done != 0) mst = 2;
        else if (tk != 0) begin
          if (steps == 15) done = 1;
          steps = (steps + 1) % 16;
        end
      end else mst = 0;
      since = (fl != 0) ? 0 : ((since < 64) ? since + 1 : 64);
      divc = (divc + 1) % 4;
      startPrev = startN;
      hist.push_front(int'(extClkIn));
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      chk("R2/R8", "seqTick", int'(seqTick), expTick());
      chk("R9", "stepCount", int'(stepCount), steps);
      chk("R2", "endConv", int'(endConv), done);
      chk("R4/R5", "busy", int'(busy), (mst == 0) ? 1 : 0);
      chk("R3", "monClk", int'(monClk), mon);
      chk("R1", "clkSrcExt", int'(clkSrcExt), (since < 64) ? 1 : 0);
      chk("R6", "sleepMode", int'(sleepMode), (!shdnN && rdN) ? 1 : 0);
      chk("R6", "napMode", int'(napMode), (!shdnN && !rdN) ? 1 : 0);
      if (seqTick) tickCnt++;
      if (monClk) monCnt++;
    end
  end

  // external pin driver
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      if (extToggle) begin
        phase++;
        if (phase >= extHalf) begin
          extClkIn = ~extClkIn;
          phase = 0;
        end
      end else begin
        extClkIn = 1'b1;
        phase = 0;
      end
    end
  end

  task automatic pulseStart();
    @(negedge clk); startN = 1'b0;
    @(negedge clk); startN = 1'b1;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #3;
      if (busy) break;
    end
  endtask

  task automatic runConv(input int extraStartAt);
    tickCnt = 0; monCnt = 0;
    pulseStart();
    if (extraStartAt > 0) begin
      repeat (extraStartAt) @(negedge clk);
      pulseStart();
    end
    waitIdle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    #3;
    chk("R5", "reset busy", int'(busy), 1);
    chk("R2", "reset endConv", int'(endConv), 1);
    chk("R1", "reset clkSrcExt", int'(clkSrcExt), 0);
    chk("R3", "reset monClk", int'(monClk), 0);
    @(negedge clk); rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R1 R2 R3: internal source, monitor enabled
    rdN = 1'b0;
    runConv(0);
    chk("R2", "internal ticks", tickCnt, 16);
    chk("R3", "monitor pulses rdN low", monCnt, 16);

    // R3: monitor silent with rdN high
    rdN = 1'b1;
    runConv(0);
    chk("R2", "internal ticks rdN high", tickCnt, 16);
    chk("R3", "monitor pulses rdN high", monCnt, 0);

    // R1 R8: external source toggling, more edges than needed
    extToggle = 1; extHalf = 3;
    repeat (12) @(negedge clk);
    #3 chk("R1", "external selected", int'(clkSrcExt), 1);
    rdN = 1'b0;
    runConv(0);
    chk("R2", "external ticks", tickCnt, 16);
    chk("R3", "external monitor", monCnt, 16);

    // R4: start during conversion ignored
    extHalf = 2;
    runConv(20);
    chk("R4", "ticks with mid start", tickCnt, 16);

    // R4 R5: start edge on the first endConv cycle
    tickCnt = 0;
    pulseStart();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #3;
      if (endConv) break;
    end
    startN = 1'b0;
    @(negedge clk); startN = 1'b1;
    repeat (6) @(negedge clk);
    #3 chk("R4", "late start ignored, busy", int'(busy), 1);
    chk("R2", "ticks before late start", tickCnt, 16);

    // R1: back to internal after hold window
    extToggle = 0;
    repeat (75) @(negedge clk);
    #3 chk("R1", "internal reselected", int'(clkSrcExt), 0);

    // R6 R7: power-down modes
    @(negedge clk); shdnN = 1'b0; rdN = 1'b1;
    @(negedge clk); #3 chk("R6", "sleep", int'(sleepMode), 1);
    @(negedge clk); rdN = 1'b0;
    @(negedge clk); #3 chk("R6", "nap", int'(napMode), 1);
    tickCnt = 0;
    pulseStart();
    repeat (8) @(negedge clk);
    #3 chk("R7", "busy in power-down", int'(busy), 1);
    chk("R7", "ticks in power-down", tickCnt, 0);
    @(negedge clk); shdnN = 1'b1;
    repeat (3) @(negedge clk);

    runConv(0);
    chk("R2", "final ticks", tickCnt, 16);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule